// File: doc/BRIEF.md
# Frame Period Drift Comparator

This block measures how far apart the pacing of two independent sample streams has drifted, using one local timebase. A free-running counter in the local clock domain acts as the clock. The counter value is captured on every input frame-start strobe, which marks a detected symbol boundary. It is also captured on every output buffer-complete strobe. The capture is taken at the symbol boundary rather than after decoding, because decoding adds jitter that depends on content. From consecutive captures the block derives the input frame period and the output buffer period. Each time an output period completes, it reports the signed difference (input period minus output period) as one error sample. When the two streams run at the same rate, this error stays near zero.

As a second measurement, on every output strobe the block reports how long ago the most recent input frame started. This arrival-to-departure delay stays constant when neither side drifts. Both strobes are already synchronous to the local clock. Each side has its own restart input, which forgets that side's history, for example after the stream is re-acquired.

Both results leave as single-cycle valid pulses with no ready signal. The block applies no back-pressure and cannot be stalled. A consumer must take each sample in the cycle its valid is high, or lose it.

Top module: `drift_period_cmp`

## Requirements
- R1: Timestamps come from a TS_W-bit counter that wraps. Every period and delay is computed modulo 2^TS_W, so a period shorter than 2^TS_W cycles is measured correctly even when the counter wraps inside it.
- R2: The input period is the number of clock cycles between the edges that sampled two consecutive accepted input strobes.
- R3: Output periods are measured the same way from the output strobes. The strobe is sampled at clock edge E. err_valid is then high for exactly the one cycle that follows edge E+1.
- R4: An error sample is produced only when both sides have at least two timestamps since reset or since their last restart. The first period on either side produces no error.
- R5: Input strobes alone never produce err_valid or delay_valid. Only an accepted output strobe can produce either.
- R6: err_value is the input period minus the output period, as a signed ERR_W-bit value. It saturates at +(2^(ERR_W-1))-1 and -(2^(ERR_W-1)).
- R7: The error uses the most recent complete input period. If several input strobes arrive between two output strobes, only the last one counts. An input strobe in the same cycle as the output strobe is included.
- R8: A restart clears the history of its own side only. A restart takes priority over a strobe on that side in the same cycle, and that strobe is ignored.
- R9: On every accepted output strobe, the block reports delay_value and raises delay_valid, with the same timing as err_valid. This happens only when the input side holds at least one timestamp. delay_value is the output timestamp minus the latest input timestamp, modulo 2^TS_W. It is 0 when the two strobes coincide.
- R10: After reset, err_valid and delay_valid are low, and err_value and delay_value are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that runs the timestamp counter |
| rst_n | input | 1 | Active-low synchronous reset |
| in_frame_stb | input | 1 | Input frame start (symbol boundary) strobe |
| in_restart | input | 1 | Clears the history of the input side |
| out_buf_stb | input | 1 | Output buffer-complete strobe |
| out_restart | input | 1 | Clears the history of the output side |
| err_valid | output | 1 | Single-cycle pulse that qualifies err_value |
| err_value | output | ERR_W | Saturated signed difference: input period minus output period |
| delay_valid | output | 1 | Single-cycle pulse that qualifies delay_value |
| delay_value | output | TS_W | Output timestamp minus the latest input timestamp |

## Verification
The bench builds the block with TS_W=8 and ERR_W=6. With an 8-bit counter, the counter wraps every 256 cycles, so every long run crosses the wrap many times. With a 6-bit error, the limits of +31 and -32 are reached by periods only a few dozen cycles apart. This lets a sweep over pairs of input and output periods cover the whole signed range, saturation at both ends, and many input frames per output buffer. It also covers coincident strobes and restarts, within a short run.

// File: rtl/drift_pkg.sv
package drift_pkg;
  parameter int DEF_TS_W  = 32;
  parameter int DEF_ERR_W = 24;

  // How much history one side holds
  typedef enum logic [1:0] {
    MS_EMPTY = 2'd0,  // no timestamp yet
    MS_ONE   = 2'd1,  // one timestamp, no period yet
    MS_FULL  = 2'd2   // a complete period is held
  } meter_state_t;
endpackage

// File: rtl/dpc_ts_counter.sv
module dpc_ts_counter #(
  parameter int TS_W = drift_pkg::DEF_TS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] ts
);
  always_ff @(posedge clk) begin
    if (!rst_n) ts <= '0;
    else        ts <= ts + 1'b1;   // wraps modulo 2^TS_W
  end
endmodule

// File: rtl/dpc_period_meter.sv
module dpc_period_meter #(
  parameter int TS_W = drift_pkg::DEF_TS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] ts,
  input  logic            stb,
  input  logic            restart,
  output logic [TS_W-1:0] last_ts,
  output logic [TS_W-1:0] period,
  output logic            have_ts,
  output logic            per_valid,
  output logic            fresh,
  output logic            tick
);
  import drift_pkg::*;

  meter_state_t st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= MS_EMPTY;
      last_ts <= '0;
      period  <= '0;
      fresh   <= 1'b0;
      tick    <= 1'b0;
    end else begin
      fresh <= 1'b0;
      tick  <= 1'b0;
      if (restart) begin
        st_q <= MS_EMPTY;            // restart outranks a coincident strobe
      end else if (stb) begin
        last_ts <= ts;
        tick    <= 1'b1;
        if (st_q != MS_EMPTY) begin
          period <= ts - last_ts;    // modular difference survives wrap
          fresh  <= 1'b1;
          st_q   <= MS_FULL;
        end else begin
          st_q <= MS_ONE;
        end
      end
    end
  end

  assign have_ts   = (st_q != MS_EMPTY);
  assign per_valid = (st_q == MS_FULL);

  assert_restart_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!have_ts && !fresh && !tick));

  assert_first_suppressed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |-> $past(have_ts));
endmodule

// File: rtl/dpc_err_calc.sv
module dpc_err_calc #(
  parameter int TS_W  = drift_pkg::DEF_TS_W,
  parameter int ERR_W = drift_pkg::DEF_ERR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  in_period,
  input  logic             in_per_valid,
  input  logic [TS_W-1:0]  in_last_ts,
  input  logic             in_have,
  input  logic [TS_W-1:0]  out_period,
  input  logic             out_per_valid,
  input  logic             out_fresh,
  input  logic             out_tick,
  input  logic [TS_W-1:0]  out_last_ts,
  output logic             err_valid,
  output logic [ERR_W-1:0] err_value,
  output logic             delay_valid,
  output logic [TS_W-1:0]  delay_value
);
  localparam int DW = TS_W + 1;

  logic signed [DW-1:0] diff;
  logic [ERR_W-1:0]     sat;

  assign diff = $signed({1'b0, in_period}) - $signed({1'b0, out_period});

  generate
    if (ERR_W >= DW) begin : g_wide
      assign sat = ERR_W'(diff);
    end else begin : g_clip
      localparam logic signed [DW-1:0] ERR_MAX = DW'((2 ** (ERR_W - 1)) - 1);
      localparam logic signed [DW-1:0] ERR_MIN = DW'(-(2 ** (ERR_W - 1)));
      assign sat = (diff > ERR_MAX) ? ERR_MAX[ERR_W-1:0] :
                   (diff < ERR_MIN) ? ERR_MIN[ERR_W-1:0] : diff[ERR_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid   <= 1'b0;
      err_value   <= '0;
      delay_valid <= 1'b0;
      delay_value <= '0;
    end else begin
      err_valid   <= out_fresh && out_per_valid && in_per_valid;
      delay_valid <= out_tick && in_have;
      if (out_fresh && out_per_valid && in_per_valid) err_value <= sat;
      if (out_tick && in_have) delay_value <= out_last_ts - in_last_ts;
    end
  end

  assert_err_needs_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> $past(in_per_valid));

  assert_err_on_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> $past(out_fresh));

  assert_delay_needs_ts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    delay_valid |-> $past(in_have));

  assert_err_with_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> delay_valid);
endmodule

// File: rtl/drift_period_cmp.sv
module drift_period_cmp #(
  parameter int TS_W  = drift_pkg::DEF_TS_W,
  parameter int ERR_W = drift_pkg::DEF_ERR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_frame_stb,
  input  logic             in_restart,
  input  logic             out_buf_stb,
  input  logic             out_restart,
  output logic             err_valid,
  output logic [ERR_W-1:0] err_value,
  output logic             delay_valid,
  output logic [TS_W-1:0]  delay_value
);
  logic [TS_W-1:0] ts;
  logic [TS_W-1:0] in_last, in_period, out_last, out_period;
  logic            in_have, in_per_valid, in_fresh, in_tick;
  logic            out_have, out_per_valid, out_fresh, out_tick;
  logic            unused_meter_bits;

  assign unused_meter_bits = ^{in_fresh, in_tick, out_have};

  dpc_ts_counter #(.TS_W(TS_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .ts(ts)
  );

  dpc_period_meter #(.TS_W(TS_W)) u_in (
    .clk(clk), .rst_n(rst_n), .ts(ts), .stb(in_frame_stb), .restart(in_restart),
    .last_ts(in_last), .period(in_period), .have_ts(in_have),
    .per_valid(in_per_valid), .fresh(in_fresh), .tick(in_tick)
  );

  dpc_period_meter #(.TS_W(TS_W)) u_out (
    .clk(clk), .rst_n(rst_n), .ts(ts), .stb(out_buf_stb), .restart(out_restart),
    .last_ts(out_last), .period(out_period), .have_ts(out_have),
    .per_valid(out_per_valid), .fresh(out_fresh), .tick(out_tick)
  );

  dpc_err_calc #(.TS_W(TS_W), .ERR_W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n),
    .in_period(in_period), .in_per_valid(in_per_valid),
    .in_last_ts(in_last), .in_have(in_have),
    .out_period(out_period), .out_per_valid(out_per_valid),
    .out_fresh(out_fresh), .out_tick(out_tick), .out_last_ts(out_last),
    .err_valid(err_valid), .err_value(err_value),
    .delay_valid(delay_valid), .delay_value(delay_value)
  );

  assert_in_alone_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_valid || err_valid) |-> $past(out_tick));
endmodule

// File: tb/drift_period_cmp_tb.sv
module drift_period_cmp_tb;
  localparam int TS_W  = 8;
  localparam int ERR_W = 6;
  localparam int MASK  = (1 << TS_W) - 1;
  localparam int EMAX  = (1 << (ERR_W - 1)) - 1;
  localparam int EMIN  = -(1 << (ERR_W - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_frame_stb = 1'b0, in_restart = 1'b0, out_buf_stb = 1'b0, out_restart = 1'b0;
  logic             err_valid, delay_valid;
  logic [ERR_W-1:0] err_value;
  logic [TS_W-1:0]  delay_value;

  always #5 clk = ~clk;

  drift_period_cmp #(.TS_W(TS_W), .ERR_W(ERR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_frame_stb(in_frame_stb), .in_restart(in_restart),
    .out_buf_stb(out_buf_stb), .out_restart(out_restart),
    .err_valid(err_valid), .err_value(err_value),
    .delay_valid(delay_valid), .delay_value(delay_value)
  );

  int checks = 0, fails = 0, n_err = 0, n_dly = 0, n_sat = 0;
  bit done = 0;
  string phase = "R10";

  // Reference model from the requirements
  int bc = 0, il = 0, ip = 0, ol = 0, op = 0;
  bit ih = 0, ipv = 0, oh = 0;
  bit s1_ev = 0, s1_dv = 0, s2_ev = 0, s2_dv = 0;
  int s1_e = 0, s1_d = 0, s2_e = 0, s2_d = 0;

  function automatic int sat(int d);
    if (d > EMAX) return EMAX;
    if (d < EMIN) return EMIN;
    return d;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      bc = 0; ih = 0; ipv = 0; oh = 0;
      s1_ev = 0; s1_dv = 0; s2_ev = 0; s2_dv = 0;
    end else begin
      s2_ev = s1_ev; s2_dv = s1_dv; s2_e = s1_e; s2_d = s1_d;
      s1_ev = 0; s1_dv = 0;
      if (in_restart) begin ih = 0; ipv = 0; end
      else if (in_frame_stb) begin
        if (ih) begin ip = (bc - il) & MASK; ipv = 1; end
        il = bc; ih = 1;
      end
      if (out_restart) oh = 0;
      else if (out_buf_stb) begin
        if (oh) begin
          op = (bc - ol) & MASK;
          if (ipv) begin s1_ev = 1; s1_e = sat(ip - op); end
        end
        if (ih) begin s1_dv = 1; s1_d = (bc - il) & MASK; end
        ol = bc; oh = 1;
      end
      bc++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (err_valid) n_err++;
      if (delay_valid) n_dly++;
      if (err_valid && ($signed(err_value) == EMAX || $signed(err_value) == EMIN)) n_sat++;
      if (err_valid || s2_ev) begin
        checks++;
        if (err_valid !== s2_ev || (s2_ev && $signed(err_value) != s2_e)) begin
          fails++;
          $display("FAIL %s err actual v=%0b e=%0d expected v=%0b e=%0d",
                   phase, err_valid, $signed(err_value), s2_ev, s2_e);
        end
      end
      if (delay_valid || s2_dv) begin
        checks++;
        if (delay_valid !== s2_dv || (s2_dv && int'(delay_value) != s2_d)) begin
          fails++;
          $display("FAIL R9 delay actual v=%0b d=%0d expected v=%0b d=%0d",
                   delay_valid, delay_value, s2_dv, s2_d);
        end
      end
    end
  end

  task automatic drive(bit i, bit o, bit ri, bit ro);
    @(negedge clk);
    in_frame_stb = i; out_buf_stb = o; in_restart = ri; out_restart = ro;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) drive(0, 0, 0, 0);
  endtask

  task automatic expect_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run_streams(int p, int q, int n);
    drive(0, 0, 1, 1);
    for (int c = 0; c < n; c++) drive((c % p) == 0, (c % q) == 0, 0, 0);
    idle(4);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", fails, checks);
  endtask

  initial begin
    int e0, d0;
    repeat (3) @(negedge clk);
    // R10: reset state
    expect_eq("R10", "err_valid", err_valid, 0);
    expect_eq("R10", "delay_valid", delay_valid, 0);
    expect_eq("R10", "err_value", err_value, 0);
    expect_eq("R10", "delay_value", delay_value, 0);
    rst_n = 1'b1;
    idle(3);

    // R4: no error until both sides hold two timestamps
    phase = "R4"; e0 = n_err; d0 = n_dly;
    drive(0, 1, 0, 0); idle(5);
    drive(1, 0, 0, 0); idle(9);
    drive(0, 1, 0, 0); idle(9);
    drive(1, 0, 0, 0); idle(14);
    drive(0, 1, 0, 0); idle(5);
    expect_eq("R4", "error pulses", n_err - e0, 1);
    expect_eq("R9", "delay pulses", n_dly - d0, 2);

    // R5: input strobes alone are silent
    phase = "R5"; drive(0, 0, 1, 1); e0 = n_err; d0 = n_dly;
    for (int k = 0; k < 10; k++) begin drive(1, 0, 0, 0); idle(6); end
    idle(4);
    expect_eq("R5", "error pulses", n_err - e0, 0);
    expect_eq("R5", "delay pulses", n_dly - d0, 0);

    // R7: coincident strobes and several inputs per output
    phase = "R7";
    drive(0, 0, 1, 1);
    for (int k = 0; k < 4; k++) begin drive(1, 1, 0, 0); idle(12); end
    run_streams(4, 30, 200);
    run_streams(7, 33, 200);

    // R8: restart outranks a strobe on its side
    phase = "R8";
    run_streams(10, 10, 50);
    e0 = n_err; d0 = n_dly;
    drive(1, 0, 1, 0); idle(9);
    drive(0, 1, 0, 0); idle(5);
    expect_eq("R8", "error after input restart", n_err - e0, 0);
    expect_eq("R8", "delay after input restart", n_dly - d0, 0);
    drive(1, 0, 0, 0); idle(8); drive(1, 0, 0, 0); idle(8);
    e0 = n_err;
    drive(0, 1, 0, 1); idle(10);
    drive(0, 1, 0, 0); idle(5);
    expect_eq("R8", "error after output restart", n_err - e0, 0);
    drive(0, 1, 0, 0); idle(5);
    expect_eq("R8", "error after two output stamps", n_err - e0, 1);

    // R1: many counter wraps with equal periods
    phase = "R1"; e0 = n_err;
    run_streams(97, 97, 1000);
    expect_eq("R1", "pulses across wraps", (n_err - e0) > 5, 1);

    // R3: varied output period
    phase = "R3"; run_streams(50, 23, 600);

    // R6: saturation at both limits
    phase = "R6"; d0 = n_sat;
    run_streams(150, 4, 700);
    run_streams(4, 150, 700);
    expect_eq("R6", "saturated samples seen", (n_sat - d0) > 2, 1);

    // R2: sweep of period pairs
    phase = "R2";
    foreach (plist[a]) foreach (plist[b]) run_streams(plist[a], plist[b], 520);

    done = 1;
    summary();
    $finish;
  end

  int plist[7] = '{3, 9, 16, 25, 40, 90, 170};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule